// File: doc/BRIEF.md
# Compressed Halfword Instruction Expander

This block turns 16-bit compressed instruction halfwords into the equivalent 32-bit base-ISA instruction words. It takes one halfword per accepted cycle over a valid/ready handshake. One cycle later it presents the expanded word with a valid strobe and an illegal flag. A front end that has already split the fetch stream into halfwords feeds it, and the word it produces goes straight to the normal decoder.

The block recognises the following forms:

- a prefix halfword that carries high immediate bits;
- the canonical no-op;
- a register move;
- doubleword load and store with an 8-byte-scaled offset;
- an immediate add to the stack pointer.

A prefix halfword produces no output. Its low eleven bits are held and merged into the immediate of the instruction that follows, and are then dropped. Three-bit compressed register codes select from a fixed group of eight base registers. Every other halfword expands to a word whose major opcode is 0x3E, which the decoder traps as illegal.

A flush input discards any held prefix and any pending output, and it blocks intake for that cycle.

Top module: `hx_expander`

## Requirements
- R1: After reset, `out_valid` is 0 and no prefix is held, so the first load is expanded without one.
- R2: An accepted halfword whose bits [15:11] are 11110 while no prefix is held produces no output, and its bits [10:0] are kept as the prefix.
- R3: The halfword 0x6500 expands to 0x00000000, with or without a prefix ahead of it.
- R4: A halfword with bits [15:8] = 0x67 expands to opcode 0x09 (add immediate) in [31:26], with bits [4:0] in [25:21], the remapped code from bits [7:5] in [20:16], and a zero immediate. The 3-bit codes 0..7 map to registers 16, 17, 2, 3, 4, 5, 6, 7.
- R5: A halfword with bits [15:11] = 00111 expands to opcode 0x37 (doubleword load). Its rs is the remapped bits [10:8], its rt is the remapped bits [7:5], and its immediate is bits [4:0] times 8, zero-extended to 16 bits.
- R6: A halfword with bits [15:8] = 0xF9 expands like R5, but with opcode 0x3F (doubleword store).
- R7: When a prefix is held, the load or store immediate is {bits [4:0], prefix[10:0]}.
- R8: A halfword with bits [15:8] = 0xFB expands to opcode 0x19 with rs = rt = 29. Its immediate is bits [7:0] shifted left by 3, sign-extended from bit 10.
- R9: When a prefix is held, the stack-pointer immediate is (prefix[10:0] << 5) + bits [7:0], truncated to 16 bits.
- R10: Any other halfword expands to 0xF8000000 with `out_illegal` set.
- R11: A held prefix applies to exactly one following instruction and is then cleared.
- R12: A prefix halfword accepted while a prefix is already held outputs 0xF8000000 with `out_illegal` set, and it clears the held prefix.
- R13: While `flush` is 1, `in_ready` is 0. The next cycle has no output valid and no prefix held.
- R14: Every accepted non-prefix halfword gives `out_valid` = 1 on the next cycle, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard held prefix and pending output |
| in_valid | input | 1 | Halfword on `in_half` is offered |
| in_ready | output | 1 | Halfword can be taken this cycle |
| in_half | input | 16 | Compressed instruction halfword |
| out_valid | output | 1 | Expanded word is valid |
| out_word | output | 32 | Expanded 32-bit instruction |
| out_illegal | output | 1 | Expanded word is the illegal trap word |

## Verification
The properties assume that `in_half` is stable while it is being sampled, and that `flush` may arrive in any cycle, including one in which a halfword is offered. The properties also assume that no downstream stall exists: `out_valid` is a one-cycle pulse per accepted instruction. The stimulus drives inputs only on the falling edge. It releases `in_valid` between directed steps. It raises `flush` both while a prefix is held and in the cycle after an output, so that every clause of the flush property is reached.

// File: rtl/hx_pkg.sv
package hx_pkg;

  localparam int HALF_W   = 16;
  localparam int WORD_W   = 32;
  localparam int PFX_W    = 11;
  localparam int REG_W    = 5;
  localparam int CODE_W   = 3;
  localparam int OP_W     = 6;
  localparam int IMM_W    = 16;
  localparam int OFF_W    = 5;
  localparam int SPI_W    = 8;
  localparam int SCALE_SH = 3;

  localparam logic [OP_W-1:0]  OP_ADDIU  = 6'h09;
  localparam logic [OP_W-1:0]  OP_DADDIU = 6'h19;
  localparam logic [OP_W-1:0]  OP_LD     = 6'h37;
  localparam logic [OP_W-1:0]  OP_SD     = 6'h3F;
  localparam logic [OP_W-1:0]  OP_TRAP   = 6'h3E;
  localparam logic [REG_W-1:0] REG_SP    = 5'd29;

  typedef enum logic [2:0] {
    K_EXT,
    K_NOP,
    K_MOVE,
    K_LD,
    K_SD,
    K_SPADD,
    K_BAD
  } kind_e;

  function automatic logic [REG_W-1:0] map_reg(input logic [CODE_W-1:0] code);
    logic [REG_W-1:0] r;
    case (code)
      3'd0:    r = 5'd16;
      3'd1:    r = 5'd17;
      default: r = {2'b00, code};
    endcase
    return r;
  endfunction

  function automatic logic [IMM_W-1:0] ldst_imm(input logic held,
                                                input logic [PFX_W-1:0] pfx,
                                                input logic [OFF_W-1:0] off);
    logic [IMM_W-1:0] v;
    if (held) v = {off, pfx};
    else      v = {{(IMM_W-OFF_W-SCALE_SH){1'b0}}, off, {SCALE_SH{1'b0}}};
    return v;
  endfunction

  function automatic logic [IMM_W-1:0] sp_imm(input logic held,
                                              input logic [PFX_W-1:0] pfx,
                                              input logic [SPI_W-1:0] k);
    logic [IMM_W-1:0] v;
    if (held) v = {pfx, 5'b00000} + {{(IMM_W-SPI_W){1'b0}}, k};
    else      v = {{(IMM_W-SPI_W-SCALE_SH){k[SPI_W-1]}}, k, {SCALE_SH{1'b0}}};
    return v;
  endfunction

  function automatic logic [WORD_W-1:0] itype(input logic [OP_W-1:0] op,
                                              input logic [REG_W-1:0] rs,
                                              input logic [REG_W-1:0] rt,
                                              input logic [IMM_W-1:0] imm);
    return {op, rs, rt, imm};
  endfunction

endpackage

// File: rtl/hx_classify.sv
module hx_classify
  import hx_pkg::*;
(
  input  logic [HALF_W-1:0] half,
  output kind_e             kind
);

  logic is_ext, is_nop, is_move, is_ld, is_sd, is_sp;

  assign is_ext  = (half[15:11] == 5'b11110);
  assign is_nop  = (half == 16'h6500);
  assign is_move = (half[15:8] == 8'h67);
  assign is_ld   = (half[15:11] == 5'b00111);
  assign is_sd   = (half[15:8] == 8'hF9);
  assign is_sp   = (half[15:8] == 8'hFB);

  always_comb begin
    if (is_ext)       kind = K_EXT;
    else if (is_nop)  kind = K_NOP;
    else if (is_move) kind = K_MOVE;
    else if (is_ld)   kind = K_LD;
    else if (is_sd)   kind = K_SD;
    else if (is_sp)   kind = K_SPADD;
    else              kind = K_BAD;
  end

endmodule

// File: rtl/hx_prefix.sv
module hx_prefix
  import hx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             is_ext,
  input  logic [PFX_W-1:0] bits_in,
  output logic             held,
  output logic [PFX_W-1:0] bits
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      held <= 1'b0;
      bits <= '0;
    end else if (take) begin
      if (is_ext && !held) begin
        held <= 1'b1;
        bits <= bits_in;
      end else begin
        held <= 1'b0;
        bits <= '0;
      end
    end
  end

endmodule

// File: rtl/hx_build.sv
module hx_build
  import hx_pkg::*;
(
  input  kind_e             kind,
  input  logic [PFX_W-1:0]  low,
  input  logic              held,
  input  logic [PFX_W-1:0]  pfx,
  output logic [WORD_W-1:0] word,
  output logic              illegal
);

  logic [REG_W-1:0] r_hi, r_mid;
  logic [IMM_W-1:0] mem_imm, stk_imm;

  assign r_hi    = map_reg(low[10:8]);
  assign r_mid   = map_reg(low[7:5]);
  assign mem_imm = ldst_imm(held, pfx, low[4:0]);
  assign stk_imm = sp_imm(held, pfx, low[7:0]);

  always_comb begin
    illegal = 1'b0;
    case (kind)
      K_NOP:   word = '0;
      K_MOVE:  word = itype(OP_ADDIU, low[4:0], r_mid, '0);
      K_LD:    word = itype(OP_LD, r_hi, r_mid, mem_imm);
      K_SD:    word = itype(OP_SD, r_hi, r_mid, mem_imm);
      K_SPADD: word = itype(OP_DADDIU, REG_SP, REG_SP, stk_imm);
      default: begin
        word    = {OP_TRAP, {(WORD_W-OP_W){1'b0}}};
        illegal = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/hx_expander.sv
module hx_expander
  import hx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HALF_W-1:0] in_half,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output logic              out_illegal
);

  kind_e             kind;
  logic              ev_accept;
  logic              ev_ext;
  logic              ev_emit;
  logic              pfx_held;
  logic [PFX_W-1:0]  pfx_bits;
  logic [WORD_W-1:0] nxt_word;
  logic              nxt_illegal;

  assign in_ready  = !flush;
  assign ev_accept = in_valid && in_ready;
  assign ev_ext    = (kind == K_EXT);
  assign ev_emit   = ev_accept && (!ev_ext || pfx_held);

  hx_classify u_cls (
    .half (in_half),
    .kind (kind)
  );

  hx_prefix u_pfx (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush),
    .take    (ev_accept),
    .is_ext  (ev_ext),
    .bits_in (in_half[PFX_W-1:0]),
    .held    (pfx_held),
    .bits    (pfx_bits)
  );

  hx_build u_bld (
    .kind    (kind),
    .low     (in_half[PFX_W-1:0]),
    .held    (pfx_held),
    .pfx     (pfx_bits),
    .word    (nxt_word),
    .illegal (nxt_illegal)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= ev_emit;
      if (ev_emit) begin
        out_word    <= nxt_word;
        out_illegal <= nxt_illegal;
      end
    end
  end

endmodule

// File: rtl/hx_expander_chk.sv
module hx_expander_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        in_ready,
  input logic [15:0] in_half,
  input logic        ev_accept,
  input logic        ev_ext,
  input logic        pfx_held,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        out_illegal
);

  // R14
  emit_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_ext) |=> out_valid);

  // R2
  ext_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_ext && !pfx_held) |=> (!out_valid && pfx_held));

  // R12
  double_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && ev_ext && pfx_held) |=> (out_valid && out_illegal && !pfx_held));

  // R11
  consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && !ev_ext) |=> !pfx_held);

  // R13
  flush_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  // R13
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !pfx_held));

  // R10
  trap_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (out_word[31:26] == 6'h3E));

  // R3
  nop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && in_half == 16'h6500) |=> (out_word == 32'h0 && !out_illegal));

endmodule

bind hx_expander hx_expander_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_ready    (in_ready),
  .in_half     (in_half),
  .ev_accept   (ev_accept),
  .ev_ext      (ev_ext),
  .pfx_held    (pfx_held),
  .out_valid   (out_valid),
  .out_word    (out_word),
  .out_illegal (out_illegal)
);

// File: tb/hx_expander_bench.sv
module hx_expander_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = 16'h0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hx_expander u_hx_expander (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_half(in_half), .out_valid(out_valid),
    .out_word(out_word), .out_illegal(out_illegal)
  );

  // {has_prefix, prefix, halfword, expected word, expected illegal}
  localparam int NV = 17;
  localparam logic [65:0] VEC [0:NV-1] = '{
    {1'b0, 16'h0000, 16'h6500, 32'h00000000, 1'b0}, // R3
    {1'b0, 16'h0000, 16'h67E3, 32'h24670000, 1'b0}, // R4
    {1'b0, 16'h0000, 16'h670A, 32'h25500000, 1'b0}, // R4
    {1'b0, 16'h0000, 16'h3A45, 32'hDC420028, 1'b0}, // R5
    {1'b0, 16'h0000, 16'h3FFF, 32'hDCE700F8, 1'b0}, // R5
    {1'b0, 16'h0000, 16'hF920, 32'hFE310000, 1'b0}, // R6
    {1'b0, 16'h0000, 16'hF9C3, 32'hFE260018, 1'b0}, // R6
    {1'b0, 16'h0000, 16'hFB10, 32'h67BD0080, 1'b0}, // R8
    {1'b0, 16'h0000, 16'hFBF0, 32'h67BDFF80, 1'b0}, // R8
    {1'b0, 16'h0000, 16'hFB7F, 32'h67BD03F8, 1'b0}, // R8
    {1'b0, 16'h0000, 16'h1234, 32'hF8000000, 1'b1}, // R10
    {1'b0, 16'h0000, 16'h6501, 32'hF8000000, 1'b1}, // R10
    {1'b1, 16'hF123, 16'h3A45, 32'hDC422923, 1'b0}, // R7
    {1'b1, 16'hF7FF, 16'hF93F, 32'hFE31FFFF, 1'b0}, // R7
    {1'b1, 16'hF001, 16'hFB05, 32'h67BD0025, 1'b0}, // R9
    {1'b1, 16'hF7FF, 16'hFB40, 32'h67BD0020, 1'b0}, // R9
    {1'b1, 16'hF000, 16'h6500, 32'h00000000, 1'b0}  // R3
  };

  function automatic string vtag(input int i);
    case (i)
      0, 16:       return "R3";
      1, 2:        return "R4";
      3, 4:        return "R5";
      5, 6:        return "R6";
      7, 8, 9:     return "R8";
      10, 11:      return "R10";
      12, 13:      return "R7";
      default:     return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] h);
    @(negedge clk);
    in_valid = 1'b1;
    in_half  = h;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string req, input logic [31:0] w, input logic ill);
    check(req, {31'b0, out_valid}, 32'd1);
    check(req, out_word, w);
    check(req, {31'b0, out_illegal}, {31'b0, ill});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1", {31'b0, out_valid}, 32'd0);
    check("R13", {31'b0, in_ready}, 32'd1);

    // R1: first load after reset has no prefix applied
    push(16'h3A45);
    expect_out("R1", 32'hDC420028, 1'b0);
    idle();

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][65]) begin
        push(VEC[i][64:49]);
        // R2: prefix gives no output
        check("R2", {31'b0, out_valid}, 32'd0);
      end
      push(VEC[i][48:33]);
      expect_out(vtag(i), VEC[i][32:1], VEC[i][0]);
      idle();
      // R14: no output without a new halfword
      @(posedge clk); #1;
      check("R14", {31'b0, out_valid}, 32'd0);
    end

    // R11: prefix used once only
    push(16'hF123);
    push(16'h3A45);
    expect_out("R11", 32'hDC422923, 1'b0);
    push(16'h3A45);
    expect_out("R11", 32'hDC420028, 1'b0);
    idle();

    // R12: back-to-back prefixes
    push(16'hF001);
    push(16'hF002);
    expect_out("R12", 32'hF8000000, 1'b1);
    push(16'h3A45);
    expect_out("R12", 32'hDC420028, 1'b0);
    idle();

    // R13: flush drops held prefix and blocks intake
    push(16'hF123);
    @(negedge clk);
    flush = 1'b1;
    in_valid = 1'b1;
    in_half = 16'h6500;
    #1;
    check("R13", {31'b0, in_ready}, 32'd0);
    @(posedge clk); #1;
    check("R13", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    flush = 1'b0;
    in_valid = 1'b0;
    push(16'h3A45);
    expect_out("R13", 32'hDC420028, 1'b0);
    // R13: flush right after an output clears it
    @(negedge clk);
    in_valid = 1'b0;
    flush = 1'b1;
    @(posedge clk); #1;
    check("R13", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    flush = 1'b0;

    // R1: reset drops a held prefix
    push(16'hF7FF);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    push(16'hF93F);
    expect_out("R1", 32'hFE3100F8, 1'b0);
    idle();

    finish_run();
  end

endmodule